// File: doc/BRIEF.md
# Invalid Block Table Builder

This block runs once after power-up, before any normal traffic reaches a raw NAND array. It asks the bus sequencer for one spare-area byte (the factory bad-block marker) from each of the two lowest pages of every erase block, from block 0 up to the last block. A block is recorded as unusable when either of those bytes differs from the erased value FFh. The result is a one-bit-per-block table held in flops and a running count of unusable blocks.

When the walk finishes, the block raises a completion flag. It also raises a warning flag when the table looks implausible: block 0 is reported bad, or more blocks are bad than the configured limit allows. Address-mapping logic later reads the table one block at a time through a registered lookup port.

A new scan can be started at any time the engine is not walking. Starting a scan clears the table and the count.

Top module: `ibt_builder`

## Requirements
- R1: After reset, `scan_busy`, `scan_done`, `scan_anomaly`, `seq_req_valid` and `qry_bad` are 0, and `bad_count` is 0.
- R2: A `scan_start` pulse is taken only while the engine is idle or done, and `scan_busy` is 1 in the cycle after it is taken. A pulse while `scan_busy` is 1 has no effect: the request sequence carries on unchanged.
- R3: Requests are issued in this order: block 0 upward, and within each block page 0 then page 1.
  - `seq_req_row` is block*16 + page, with the block in bits [13:4] and the page in bits [3:0].
  - `seq_req_cmd` is 50h and `seq_req_col` is 5, which is spare byte 5, column 517.
  - A request holds `seq_req_valid` and its row steady until `seq_req_ready`, and the next request waits for the response to the previous one.
- R4: A block's table bit is set exactly when the response byte for page 0 or page 1 of that block is not FFh. Any non-FFh value counts, including values with a single zero bit.
- R5: When `qry_en` is 1, `qry_bad` shows the table bit of `qry_blk` in the next cycle. When `qry_en` is 0, `qry_bad` holds its value.
- R6: When the scan is done, `bad_count` equals the number of set table bits, and it never rises by more than 1 per cycle.
- R7: `scan_done` is 1 and `scan_busy` is 0 in the cycle after the response for the last block's second page is accepted.
- R8: `scan_anomaly` is 1 only while `scan_done` is 1. It is set when `bad_count` exceeds `ANOMALY_LIMIT` (default 10) or when block 0 is bad. A count exactly equal to the limit does not set it.
- R9: Starting a new scan clears every table bit and `bad_count` before the walk begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_start | input | 1 | Pulse that begins a scan |
| seq_req_valid | output | 1 | Marker read request to the sequencer |
| seq_req_ready | input | 1 | Sequencer accepts the request |
| seq_req_cmd | output | 8 | Command byte for the read (50h) |
| seq_req_col | output | 8 | Column byte within the spare area (5) |
| seq_req_row | output | 14 | Row address: block in [13:4], page in [3:0] |
| seq_rsp_valid | input | 1 | Marker byte returned |
| seq_rsp_data | input | 8 | Marker byte value |
| scan_busy | output | 1 | Walk in progress |
| scan_done | output | 1 | Walk complete, table valid |
| scan_anomaly | output | 1 | Too many bad blocks, or block 0 bad |
| bad_count | output | 11 | Number of blocks marked bad |
| qry_en | input | 1 | Lookup strobe |
| qry_blk | input | 10 | Block index to look up |
| qry_bad | output | 1 | Table bit of the looked-up block, one cycle later |

## Verification
Each result has a fixed due cycle, and the bench samples on the falling edge before that cycle ends.

- **Start:** `scan_busy` is due one edge after the start pulse.
- **Completion:** `scan_done`, the final table bits and `bad_count` are due one edge after the edge that accepts the last response. The sequencer model checks `scan_done` at the very next falling edge.
- **Lookup:** a result is due one edge after `qry_en`, so the bench drives a block index, waits one falling edge and compares against a bit it computes from the marker pattern.

A reduced configuration of 32 blocks and a limit of 3 lets every block be swept after every scan. Response latency varies between 0 and 2 cycles from request to request.

// File: rtl/ibt_pkg.sv
// Shared constants and types for the invalid block table builder.
// Assumes a spare-area read command that positions the column inside the spare bytes.
package ibt_pkg;
    localparam logic [7:0] CMD_SPARE_READ = 8'h50;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        W_IDLE,
        W_REQ,
        W_WAIT,
        W_DONE
    } walk_state_t;
endpackage

// File: rtl/ibt_walker.sv
// Walks every block and page pair, issuing one marker read at a time.
// Assumes the sequencer answers each accepted request with exactly one response.
module ibt_walker
    import ibt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 16,
    parameter int SCAN_PAGES      = 2
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           start,
    input  logic                                           req_ready,
    input  logic                                           rsp_valid,
    input  logic [7:0]                                     rsp_data,
    output logic                                           req_valid,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] req_row,
    output logic                                           busy,
    output logic                                           done,
    output logic                                           clear,
    output logic                                           mark_valid,
    output logic [$clog2(NUM_BLOCKS)-1:0]                  mark_blk,
    output logic                                           mark_bad
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK);
    localparam int SP_W  = (SCAN_PAGES > 1) ? $clog2(SCAN_PAGES) : 1;
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [SP_W-1:0]  LAST_PG  = SP_W'(SCAN_PAGES - 1);

    walk_state_t       state;
    logic [BLK_W-1:0]  blk;
    logic [SP_W-1:0]   page;
    logic              bad_acc;
    logic              page_bad;
    logic              rsp_take;
    logic              last_page;
    logic [PG_W-1:0]   pg_field;

    // Decode the current step: start acceptance, response take and marker verdict.
    always_comb begin
        clear      = start && (state == W_IDLE || state == W_DONE);
        rsp_take   = (state == W_WAIT) && rsp_valid;
        page_bad   = (rsp_data != ERASED_BYTE);
        last_page  = (page == LAST_PG);
        mark_valid = rsp_take && last_page;
        mark_bad   = bad_acc || page_bad;
        mark_blk   = blk;
        pg_field   = PG_W'(page);
        req_row    = {blk, pg_field};
        req_valid  = (state == W_REQ);
        busy       = (state == W_REQ) || (state == W_WAIT);
        done       = (state == W_DONE);
    end

    // Sequence the walk: request, wait for the byte, advance page then block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= W_IDLE;
            blk     <= '0;
            page    <= '0;
            bad_acc <= 1'b0;
        end else begin
            case (state)
                W_IDLE, W_DONE: begin
                    if (clear) begin
                        state   <= W_REQ;
                        blk     <= '0;
                        page    <= '0;
                        bad_acc <= 1'b0;
                    end
                end
                W_REQ: begin
                    if (req_ready) state <= W_WAIT;
                end
                W_WAIT: begin
                    if (rsp_take) begin
                        if (last_page) begin
                            bad_acc <= 1'b0;
                            page    <= '0;
                            if (blk == LAST_BLK) begin
                                state <= W_DONE;
                            end else begin
                                blk   <= blk + 1'b1;
                                state <= W_REQ;
                            end
                        end else begin
                            bad_acc <= mark_bad;
                            page    <= page + 1'b1;
                            state   <= W_REQ;
                        end
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ibt_bitmap.sv
// One flop per block holding the bad verdict, with a registered lookup port.
// Assumes clear and mark never coincide (the walker keeps them apart).
module ibt_bitmap #(
    parameter int NUM_BLOCKS = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0] mark_blk,
    input  logic                          mark_bad,
    input  logic                          qry_en,
    input  logic [$clog2(NUM_BLOCKS)-1:0] qry_blk,
    output logic                          qry_bad
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);

    logic [NUM_BLOCKS-1:0] map_q;

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
        // Set this block's bit on a bad verdict, drop it when a scan starts.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) map_q[g] <= 1'b0;
            else if (mark_valid && mark_bad && mark_blk == BLK_W'(g)) map_q[g] <= 1'b1;
        end
    end

    // Register the looked-up bit; hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) qry_bad <= 1'b0;
        else if (qry_en) qry_bad <= (int'(qry_blk) < NUM_BLOCKS) ? map_q[qry_blk] : 1'b0;
    end
endmodule

// File: rtl/ibt_tally.sv
// Counts bad blocks and flags an implausible result.
// Assumes at most one verdict per cycle.
module ibt_tally #(
    parameter int NUM_BLOCKS    = 1024,
    parameter int ANOMALY_LIMIT = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            mark_valid,
    input  logic [$clog2(NUM_BLOCKS)-1:0]   mark_blk,
    input  logic                            mark_bad,
    output logic [$clog2(NUM_BLOCKS+1)-1:0] bad_count,
    output logic                            suspect
);
    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);

    logic first_bad;

    // Count bad verdicts and note whether block 0 was among them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bad_count <= '0;
            first_bad <= 1'b0;
        end else if (mark_valid && mark_bad) begin
            bad_count <= bad_count + 1'b1;
            if (mark_blk == '0) first_bad <= 1'b1;
        end
    end

    // Flag when the count passes the limit or block 0 is bad.
    always_comb suspect = (bad_count > CNT_W'(ANOMALY_LIMIT)) || first_bad;
endmodule

// File: rtl/ibt_builder.sv
// Top level: scan engine building the bad block table and count.
// Assumes the sequencer turns each request into a spare-area read of one byte.
module ibt_builder
    import ibt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 1024,
    parameter int PAGES_PER_BLOCK = 16,
    parameter int SCAN_PAGES      = 2,
    parameter int SPARE_BASE      = 512,
    parameter int MARKER_COL      = 517,
    parameter int ANOMALY_LIMIT   = 10
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  scan_start,
    output logic                                                  seq_req_valid,
    input  logic                                                  seq_req_ready,
    output logic [7:0]                                            seq_req_cmd,
    output logic [7:0]                                            seq_req_col,
    output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] seq_req_row,
    input  logic                                                  seq_rsp_valid,
    input  logic [7:0]                                            seq_rsp_data,
    output logic                                                  scan_busy,
    output logic                                                  scan_done,
    output logic                                                  scan_anomaly,
    output logic [$clog2(NUM_BLOCKS+1)-1:0]                       bad_count,
    input  logic                                                  qry_en,
    input  logic [$clog2(NUM_BLOCKS)-1:0]                         qry_blk,
    output logic                                                  qry_bad
);
    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int COL_OFS = MARKER_COL - SPARE_BASE;

    logic             clear;
    logic             mark_valid;
    logic [BLK_W-1:0] mark_blk;
    logic             mark_bad;
    logic             suspect;

    ibt_walker #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .SCAN_PAGES(SCAN_PAGES)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .req_ready(seq_req_ready),
        .rsp_valid(seq_rsp_valid), .rsp_data(seq_rsp_data), .req_valid(seq_req_valid),
        .req_row(seq_req_row), .busy(scan_busy), .done(scan_done), .clear(clear),
        .mark_valid(mark_valid), .mark_blk(mark_blk), .mark_bad(mark_bad)
    );

    ibt_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mark_valid(mark_valid),
        .mark_blk(mark_blk), .mark_bad(mark_bad), .qry_en(qry_en),
        .qry_blk(qry_blk), .qry_bad(qry_bad)
    );

    ibt_tally #(.NUM_BLOCKS(NUM_BLOCKS), .ANOMALY_LIMIT(ANOMALY_LIMIT)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mark_valid(mark_valid),
        .mark_blk(mark_blk), .mark_bad(mark_bad), .bad_count(bad_count), .suspect(suspect)
    );

    // Fixed command and column bytes, and the anomaly gated by completion.
    always_comb begin
        seq_req_cmd  = CMD_SPARE_READ;
        seq_req_col  = 8'(COL_OFS);
        scan_anomaly = scan_done && suspect;
    end
endmodule

// File: rtl/ibt_builder_chk.sv
// Protocol and progress checks on the builder's ports, bound to every instance.
module ibt_builder_chk #(
    parameter int ROW_W = 14,
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seq_req_valid,
    input logic             seq_req_ready,
    input logic [ROW_W-1:0] seq_req_row,
    input logic             scan_busy,
    input logic             scan_done,
    input logic             scan_anomaly,
    input logic [CNT_W-1:0] bad_count
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req_valid && !seq_req_ready) |=> (seq_req_valid && $stable(seq_req_row)));

    // R3
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req_valid |-> scan_busy);

    // R7
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_done && scan_busy));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_count != $past(bad_count)) |->
        (bad_count == $past(bad_count) + 1'b1 || bad_count == '0));

    // R8
    anomaly_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_anomaly |-> scan_done);
endmodule

bind ibt_builder ibt_builder_chk #(
    .ROW_W($clog2(NUM_BLOCKS) + $clog2(PAGES_PER_BLOCK)),
    .CNT_W($clog2(NUM_BLOCKS + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .seq_req_valid(seq_req_valid), .seq_req_ready(seq_req_ready),
    .seq_req_row(seq_req_row), .scan_busy(scan_busy), .scan_done(scan_done),
    .scan_anomaly(scan_anomaly), .bad_count(bad_count)
);

// File: tb/ibt_builder_test.sv
module ibt_builder_test;
    localparam int NB    = 32;
    localparam int PPB   = 16;
    localparam int LIM   = 3;
    localparam int BLK_W = $clog2(NB);
    localparam int ROW_W = BLK_W + $clog2(PPB);
    localparam int CNT_W = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_start = 1'b0;
    logic seq_req_valid, seq_req_ready, seq_rsp_valid;
    logic [7:0] seq_req_cmd, seq_req_col, seq_rsp_data;
    logic [ROW_W-1:0] seq_req_row;
    logic scan_busy, scan_done, scan_anomaly, qry_en, qry_bad;
    logic [CNT_W-1:0] bad_count;
    logic [BLK_W-1:0] qry_blk;

    int pass_cnt = 0;
    int fail_cnt = 0;
    int pat = 0;
    int req_idx = 0;
    int req_err = 0;

    always #5 clk = ~clk;

    ibt_builder #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .ANOMALY_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .seq_req_valid(seq_req_valid),
        .seq_req_ready(seq_req_ready), .seq_req_cmd(seq_req_cmd), .seq_req_col(seq_req_col),
        .seq_req_row(seq_req_row), .seq_rsp_valid(seq_rsp_valid), .seq_rsp_data(seq_rsp_data),
        .scan_busy(scan_busy), .scan_done(scan_done), .scan_anomaly(scan_anomaly),
        .bad_count(bad_count), .qry_en(qry_en), .qry_blk(qry_blk), .qry_bad(qry_bad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] marker(input int p, input int b, input int pg);
        case (p)
            1: begin
                if (b % 5 == 3 && pg == 0) return 8'h00;
                if (b % 7 == 2 && pg == 1) return 8'hF0;
            end
            2: begin
                if (b == 5 && pg == 1) return 8'h7F;
                if (b == NB - 1 && pg == 0) return 8'hFE;
            end
            3: if (b == 0 && pg == 0) return 8'h00;
            4: if (b >= 1 && b <= LIM && pg == b % 2) return 8'h80;
            5: if (b >= 1 && b <= LIM + 1 && pg == 1) return 8'h01;
            default: ;
        endcase
        return 8'hFF;
    endfunction

    function automatic bit exp_bad(input int p, input int b);
        return marker(p, b, 0) != 8'hFF || marker(p, b, 1) != 8'hFF;
    endfunction

    // Sequencer model: accepts each request, checks its order (R3), answers after 0..2 cycles.
    initial begin
        seq_req_ready = 1'b0;
        seq_rsp_valid = 1'b0;
        seq_rsp_data  = 8'h00;
        forever begin
            @(negedge clk);
            seq_rsp_valid = 1'b0;
            seq_req_ready = 1'b0;
            if (rst_n && seq_req_valid) begin
                int b, pg;
                b  = int'(seq_req_row) / PPB;
                pg = int'(seq_req_row) % PPB;
                if (int'(seq_req_row) != (req_idx / 2) * PPB + req_idx % 2 ||
                    seq_req_cmd != 8'h50 || seq_req_col != 8'd5) req_err++;
                seq_req_ready = 1'b1;
                @(negedge clk);
                seq_req_ready = 1'b0;
                repeat (req_idx % 3) @(negedge clk);
                seq_rsp_valid = 1'b1;
                seq_rsp_data  = marker(pat, b, pg);
                req_idx++;
                if (req_idx == 2 * NB) begin
                    @(negedge clk);
                    seq_rsp_valid = 1'b0;
                    // R7: done one edge after the last response
                    check(scan_done && !scan_busy, "R7 done timing", int'(scan_done), 1);
                end
            end
        end
    end

    task automatic run_scan(input int p, input bit poke_mid);
        int t, exp_cnt;
        bit exp_anom;
        pat = p;
        req_idx = 0;
        req_err = 0;
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        // R2: busy one edge after start
        check(scan_busy == 1'b1, "R2 busy after start", int'(scan_busy), 1);
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            scan_start = 1'b1;
            @(negedge clk);
            scan_start = 1'b0;
        end
        t = 0;
        while (!scan_done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(scan_done == 1'b1, "R7 scan completes", int'(scan_done), 1);
        // R3 order, count and fixed bytes; R2 mid-scan start has no effect
        check(req_err == 0 && req_idx == 2 * NB, "R3 request order", req_idx, 2 * NB);
        exp_cnt = 0;
        for (int b = 0; b < NB; b++) if (exp_bad(p, b)) exp_cnt++;
        exp_anom = (exp_cnt > LIM) || exp_bad(p, 0);
        // R6 and R9: count restarts from zero each scan
        check(int'(bad_count) == exp_cnt, "R6 bad count", int'(bad_count), exp_cnt);
        check(scan_anomaly == exp_anom, "R8 anomaly", int'(scan_anomaly), int'(exp_anom));
        for (int b = 0; b < NB; b++) begin
            qry_en  = 1'b1;
            qry_blk = BLK_W'(b);
            @(negedge clk);
            // R4 per-block verdict, R5 one-cycle lookup, R9 stale bits cleared
            check(qry_bad == exp_bad(p, b), "R4 table bit", int'(qry_bad), int'(exp_bad(p, b)));
        end
        qry_en = 1'b0;
    endtask

    initial begin
        qry_en  = 1'b0;
        qry_blk = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!scan_busy && !scan_done && !seq_req_valid, "R1 reset flags", int'(scan_busy), 0);
        check(bad_count == '0 && !scan_anomaly && !qry_bad, "R1 reset count", int'(bad_count), 0);

        run_scan(1, 1'b1);
        // R5: with qry_en low the result holds (block 31 good, block 3 bad)
        qry_blk = BLK_W'(3);
        @(negedge clk);
        @(negedge clk);
        check(qry_bad == 1'b0, "R5 hold without strobe", int'(qry_bad), 0);
        run_scan(0, 1'b0);
        run_scan(2, 1'b0);
        run_scan(3, 1'b0);
        run_scan(4, 1'b0);
        run_scan(5, 1'b0);

        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fail_cnt++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end
endmodule